// File: doc/BRIEF.md
# Register Scoreboard Issue Check

This block is the issue interlock of an in-order machine whose instructions name one destination register and two source registers. It holds one pending-write flag per architectural register. A flag at 0 means the register holds valid data. A flag at 1 means a result for that register is still in flight, so its contents are stale. Each decoded instruction is offered with its three register indices. In the same cycle the block answers with either dispatch or stall. For a stall it also reports whether the cause is a read-after-write (RAW) hazard, a write-after-write (WAW) hazard, or both.

Dispatching an instruction marks its destination as pending at the clock edge that accepts it. A writeback from a functional unit clears the flag of the register it names. A writeback is seen in the same cycle it arrives, so an instruction waiting on that register issues without losing a cycle. Register 0 can be set up as a constant that is never pending.

Top module: `regsb_top`

## Requirements
- R1: After reset every flag is clear, so any instruction offered right after reset dispatches.
- R2: A dispatched instruction sets the flag of its destination at the accepting clock edge. From the next cycle on, an instruction that reads that register stalls.
- R3: An offered instruction stalls with cause code 2'b01 (RAW only) when either source flag is set and the destination flag is clear.
- R4: An offered instruction stalls with cause code 2'b10 (WAW only) when only the destination flag is set. It stalls with cause code 2'b11 when the destination flag and at least one source flag are set.
- R5: When no flag named by an offered instruction is set, dispatch is 1, stall is 0 and the cause is 2'b00. With no instruction offered, stall, dispatch and cause are all 0. Stall and dispatch are never 1 together.
- R6: A writeback clears the flag of the register it names at the next clock edge.
- R7: When a dispatch and a writeback name the same register in the same cycle, that register's flag is set afterwards.
- R8: A register being written back in the current cycle counts as valid for all three lookups of the instruction offered in that cycle.
- R9: When register 0 is configured as constant (the default), dispatching to register 0 leaves it valid, and reading register 0 never stalls.
- R10: A stalled instruction changes no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| iss_valid | input | 1 | An instruction is offered this cycle |
| iss_dst | input | IDXW | Destination register index |
| iss_src_a | input | IDXW | First source register index |
| iss_src_b | input | IDXW | Second source register index |
| wb_valid | input | 1 | A result is written back this cycle |
| wb_idx | input | IDXW | Register written back |
| stall | output | 1 | Offered instruction must wait |
| dispatch | output | 1 | Offered instruction is accepted |
| hazard_cause | output | 2 | 00 none, 01 RAW, 10 WAW, 11 both |

## Verification
The bench builds each reachable pattern of pending flags over eight registers. For every pattern it sweeps all destination and source triples, which catches a lookup that reads the wrong index or reports the wrong cause code. For a subset of patterns it also sweeps every writeback register. A design without the same-cycle bypass would then stall on a register being released, and one that applies the bypass to the wrong lookup would give a wrong cause. Directed sequences cover the remaining cases. If the clear wins when set and clear meet on one register, a later reader dispatches on stale data. A design that lets a stalled instruction mark its destination blocks a later reader for no reason. A design that writes a flag for register 0 makes reads of register 0 stall.

// File: rtl/regsb_pkg.sv
`timescale 1ns/1ps
// Shared types for the register scoreboard issue check.
package regsb_pkg;
    // Stall reason reported alongside stall; bit 0 = RAW, bit 1 = WAW.
    typedef enum logic [1:0] {
        HZ_NONE = 2'b00,
        HZ_RAW  = 2'b01,
        HZ_WAW  = 2'b10,
        HZ_BOTH = 2'b11
    } hazard_e;
endpackage

// File: rtl/regsb_pending.sv
`timescale 1ns/1ps
// Pending-write flag array, one flag per architectural register.
// Assumes at most one set and one clear request per cycle; a set
// wins over a clear that names the same register. With ZERO_VALID
// set, register 0 has no storage and always reads as valid.
module regsb_pending #(
    parameter int NREGS      = 8,
    parameter bit ZERO_VALID = 1'b1,
    localparam int IDXW      = $clog2(NREGS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_en,
    input  logic [IDXW-1:0]  set_idx,
    input  logic             clr_en,
    input  logic [IDXW-1:0]  clr_idx,
    output logic [NREGS-1:0] busy
);
    for (genvar i = 0; i < NREGS; i++) begin : g_flag
        if (ZERO_VALID && i == 0) begin : g_const
            assign busy[i] = 1'b0;
        end else begin : g_store
            logic hit_set;
            logic hit_clr;
            // Decode whether this register is named by a request.
            always_comb begin
                hit_set = set_en && (set_idx == IDXW'(i));
                hit_clr = clr_en && (clr_idx == IDXW'(i));
            end
            // Flag update: reset clears, set has priority over clear.
            always_ff @(posedge clk) begin
                if (!rst_n)       busy[i] <= 1'b0;
                else if (hit_set) busy[i] <= 1'b1;
                else if (hit_clr) busy[i] <= 1'b0;
            end
        end
    end

    AST_SET_MARKS: assert property (@(posedge clk) disable iff (!rst_n)
        set_en && !(ZERO_VALID && set_idx == '0) |=> busy[$past(set_idx)]); // R2
    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        set_en && clr_en && set_idx == clr_idx && !(ZERO_VALID && set_idx == '0)
        |=> busy[$past(set_idx)]); // R7
    AST_WB_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en && !(set_en && set_idx == clr_idx) |=> !busy[$past(clr_idx)]); // R6
endmodule

// File: rtl/regsb_lookup.sv
`timescale 1ns/1ps
// Reads the pending flag for each requested register index. A
// register being written back in this cycle reads as valid.
// Assumes indices are below NREGS (NREGS a power of two).
module regsb_lookup #(
    parameter int NREGS = 8,
    parameter int PORTS = 3,
    localparam int IDXW = $clog2(NREGS)
) (
    input  logic [NREGS-1:0]           busy,
    input  logic                       clr_en,
    input  logic [IDXW-1:0]            clr_idx,
    input  logic [PORTS-1:0][IDXW-1:0] idx,
    output logic [PORTS-1:0]           pend
);
    logic [NREGS-1:0] eff;

    // Effective flags with the same-cycle writeback bypass applied.
    always_comb begin
        eff = busy;
        if (clr_en) eff[clr_idx] = 1'b0;
    end

    for (genvar p = 0; p < PORTS; p++) begin : g_port
        // One read of the bypassed flags per lookup port.
        always_comb pend[p] = eff[idx[p]];
    end
endmodule

// File: rtl/regsb_verdict.sv
`timescale 1ns/1ps
// Turns the three looked-up flags into stall, dispatch and cause.
// Assumes flags are already bypassed for a same-cycle writeback.
module regsb_verdict
    import regsb_pkg::*;
(
    input  logic    offered,
    input  logic    dst_pend,
    input  logic    src_a_pend,
    input  logic    src_b_pend,
    output logic    stall,
    output logic    dispatch,
    output hazard_e cause
);
    logic raw;
    logic waw;

    // Classify the hazard and choose the outcome for an offered instruction.
    always_comb begin
        raw      = offered && (src_a_pend || src_b_pend);
        waw      = offered && dst_pend;
        stall    = raw || waw;
        dispatch = offered && !(raw || waw);
        cause    = hazard_e'({waw, raw});
    end
endmodule

// File: rtl/regsb_top.sv
`timescale 1ns/1ps
// In-order issue interlock. It decides stall or dispatch for each
// offered three-register instruction, marks the destination on
// dispatch and releases registers on writeback. Assumes one
// instruction offer and one writeback per cycle at most.
module regsb_top
    import regsb_pkg::*;
#(
    parameter int NREGS      = 8,
    parameter bit ZERO_VALID = 1'b1,
    localparam int IDXW      = $clog2(NREGS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            iss_valid,
    input  logic [IDXW-1:0] iss_dst,
    input  logic [IDXW-1:0] iss_src_a,
    input  logic [IDXW-1:0] iss_src_b,
    input  logic            wb_valid,
    input  logic [IDXW-1:0] wb_idx,
    output logic            stall,
    output logic            dispatch,
    output logic [1:0]      hazard_cause
);
    localparam int LOOKUPS = 3;

    logic [NREGS-1:0]             busy;
    logic [LOOKUPS-1:0][IDXW-1:0] look_idx;
    logic [LOOKUPS-1:0]           look_pend;
    hazard_e                      cause_e;

    // Gather lookup indices: 0 destination, 1 and 2 sources.
    always_comb begin
        look_idx[0] = iss_dst;
        look_idx[1] = iss_src_a;
        look_idx[2] = iss_src_b;
    end

    regsb_pending #(.NREGS(NREGS), .ZERO_VALID(ZERO_VALID)) u_pending (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_en  (dispatch),
        .set_idx (iss_dst),
        .clr_en  (wb_valid),
        .clr_idx (wb_idx),
        .busy    (busy)
    );

    regsb_lookup #(.NREGS(NREGS), .PORTS(LOOKUPS)) u_lookup (
        .busy    (busy),
        .clr_en  (wb_valid),
        .clr_idx (wb_idx),
        .idx     (look_idx),
        .pend    (look_pend)
    );

    regsb_verdict u_verdict (
        .offered    (iss_valid),
        .dst_pend   (look_pend[0]),
        .src_a_pend (look_pend[1]),
        .src_b_pend (look_pend[2]),
        .stall      (stall),
        .dispatch   (dispatch),
        .cause      (cause_e)
    );

    assign hazard_cause = cause_e;

    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        !(stall && dispatch)); // R5
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !iss_valid |-> !stall && !dispatch && hazard_cause == 2'b00); // R5
    AST_RAW_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid && busy[iss_src_a] && !(wb_valid && wb_idx == iss_src_a)
        |-> stall && hazard_cause[0]); // R3
    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        stall && !wb_valid |=> $stable(busy)); // R10
    AST_ZERO_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        ZERO_VALID |-> !busy[0]); // R9
endmodule

// File: tb/regsb_top_test.sv
`timescale 1ns/1ps
module regsb_top_test;
    localparam int N = 8;

    logic       clk = 1'b0;
    logic       run_clk = 1'b1;
    logic       rst_n = 1'b0;
    logic       iss_valid = 1'b0;
    logic [2:0] iss_dst = '0, iss_src_a = '0, iss_src_b = '0;
    logic       wb_valid = 1'b0;
    logic [2:0] wb_idx = '0;
    logic       stall, dispatch;
    logic [1:0] hazard_cause;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 0;
    logic [N-1:0] m_busy = '0;

    regsb_top uut (
        .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_dst(iss_dst),
        .iss_src_a(iss_src_a), .iss_src_b(iss_src_b), .wb_valid(wb_valid),
        .wb_idx(wb_idx), .stall(stall), .dispatch(dispatch),
        .hazard_cause(hazard_cause)
    );

    // 100 MHz clock that can be parked low for combinational sweeps.
    always begin
        #5;
        if (run_clk || clk) clk = ~clk;
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        #5_000_000;
        n_checks++; n_fails++;
        $display("FAIL watchdog: run did not complete (actual hung, expected done)");
        finish_run();
    end

    task automatic check(string req, logic s, logic d, logic [1:0] c);
        n_checks++;
        if (stall !== s || dispatch !== d || hazard_cause !== c) begin
            n_fails++;
            $display("FAIL %s: dst=%0d a=%0d b=%0d wb=%0b/%0d actual stall=%0b disp=%0b cause=%0b expected stall=%0b disp=%0b cause=%0b",
                req, iss_dst, iss_src_a, iss_src_b, wb_valid, wb_idx,
                stall, dispatch, hazard_cause, s, d, c);
        end
    endtask

    // Expected outcome from the model flags and the current inputs.
    task automatic check_model();
        logic [N-1:0] eff;
        logic raw, waw;
        string tag;
        eff = m_busy;
        if (wb_valid) eff[wb_idx] = 1'b0;
        raw = iss_valid && (eff[iss_src_a] || eff[iss_src_b]);
        waw = iss_valid && eff[iss_dst];
        if (wb_valid)      tag = "R8";
        else if (waw)      tag = "R4";
        else if (raw)      tag = "R3";
        else               tag = "R5";
        check(tag, raw || waw, iss_valid && !(raw || waw), {waw, raw});
    endtask

    task automatic cyc();
        @(posedge clk); #1;
    endtask

    task automatic park();
        run_clk = 1'b0; #12;
    endtask

    task automatic unpark();
        run_clk = 1'b1; cyc();
    endtask

    task automatic do_reset();
        rst_n = 1'b0; iss_valid = 0; wb_valid = 0;
        cyc(); cyc();
        rst_n = 1'b1; m_busy = '0;
    endtask

    task automatic offer(logic [2:0] d, logic [2:0] a, logic [2:0] b);
        iss_valid = 1; iss_dst = d; iss_src_a = a; iss_src_b = b;
    endtask

    initial begin
        do_reset();
        // R1 / R5: idle outputs right after reset, then a fresh instruction dispatches.
        #1; check("R5", 0, 0, 2'b00);
        offer(3'd4, 3'd5, 3'd6); #1; check("R1", 0, 1, 2'b00);
        iss_valid = 0;

        // Exhaustive sweep: every reachable flag pattern, every triple.
        for (int m = 0; m < 128; m++) begin
            logic [N-1:0] mask;
            mask = N'(m << 1);
            cyc();
            do_reset();
            for (int k = 1; k < N; k++) begin
                if (mask[k]) begin
                    offer(3'(k), 3'd0, 3'd0);
                    cyc();
                    m_busy[k] = 1'b1;   // R2: set at the accepting edge
                end
            end
            iss_valid = 0;
            park();
            for (int d = 0; d < N; d++)
                for (int a = 0; a < N; a++)
                    for (int b = 0; b < N; b++) begin
                        offer(3'(d), 3'(a), 3'(b)); #1; check_model();
                    end
            if (m % 9 == 0) begin
                for (int w = 0; w < N; w++) begin
                    wb_valid = 1; wb_idx = 3'(w);
                    for (int d = 0; d < N; d++)
                        for (int a = 0; a < N; a++)
                            for (int b = 0; b < N; b++) begin
                                offer(3'(d), 3'(a), 3'(b)); #1; check_model();
                            end
                end
                wb_valid = 0;
            end
            iss_valid = 0;
            unpark();
        end

        // R2 / R6: dispatch marks, writeback releases.
        do_reset();
        offer(3'd3, 3'd1, 3'd2); cyc();
        offer(3'd5, 3'd3, 3'd0); #1; check("R2", 1, 0, 2'b01);
        iss_valid = 0; wb_valid = 1; wb_idx = 3'd3; cyc();
        wb_valid = 0; offer(3'd5, 3'd3, 3'd3); #1; check("R6", 0, 1, 2'b00);

        // R7 / R8: same-cycle dispatch and writeback on one register.
        do_reset();
        offer(3'd6, 3'd0, 3'd0); cyc();
        offer(3'd6, 3'd1, 3'd1); wb_valid = 1; wb_idx = 3'd6; #1;
        check("R8", 0, 1, 2'b00);
        cyc();
        wb_valid = 0; offer(3'd2, 3'd6, 3'd0); #1; check("R7", 1, 0, 2'b01);
        offer(3'd6, 3'd0, 3'd0); #1; check("R7", 1, 0, 2'b10);

        // R10: a stalled instruction leaves its destination untouched.
        do_reset();
        offer(3'd2, 3'd0, 3'd0); cyc();
        offer(3'd5, 3'd2, 3'd0); #1; check("R10", 1, 0, 2'b01);
        cyc();
        offer(3'd1, 3'd5, 3'd5); #1; check("R10", 0, 1, 2'b00);

        // R4: destination and source both pending.
        offer(3'd2, 3'd2, 3'd4); #1; check("R4", 1, 0, 2'b11);

        // R9: register 0 stays valid after a dispatch names it.
        do_reset();
        offer(3'd0, 3'd0, 3'd0); cyc();
        offer(3'd0, 3'd0, 3'd0); #1; check("R9", 0, 1, 2'b00);
        iss_valid = 0; #1; check("R5", 0, 0, 2'b00);

        cyc();
        finish_run();
    end
endmodule